// File: doc/BRIEF.md
# Dataflow Task Timing Node

This block is one node of a hardware list scheduler for an acyclic task graph. One copy is built per task. It receives the task's execution time, a code that places the task on the master processor, the slave processor or the reconfigurable fabric, and the done flags and finishing times of its predecessors. From these it works out when the task can start at the earliest, whether it is ready, and when it finishes. It also gives an urgency value that a separate per-processor selector uses to break ties among software tasks.

Fabric tasks are treated as unlimited in number, so a fabric task completes on the first clock edge after its inputs are satisfied. A software task waits until its processor's selector grants it, and then starts no earlier than the time the processor has accumulated so far. The urgency value is the largest execution time among successors on other units. A successor on the same unit hands its own urgency back to this node instead. The nodes of a graph are chained so that the graph's total finishing time and an all-done flag build up from node to node.

Top module: `task_timing_node`

## Requirements
- R1: `ready` is 1 exactly when every predecessor whose `pred_mask` bit is set has its `pred_done` bit set, and it is 1 when no predecessor is selected. `asap` is the largest `pred_finish` among the selected predecessors, or 0 when none is selected. Predecessor i uses bits [16i+15:16i] of `pred_finish`.
- R2: The mapping code `unit_map` is 00 for fabric, 01 for master and 10 for slave, and 11 is treated as fabric. `master_ready`, `slave_ready` and `fabric_ready` are each `ready` AND not done AND the matching unit. At most one of them is 1, and all are 0 once the task is done.
- R3: A fabric task that is ready and not done is done on the next clock edge, with `finish` = `asap` + `exec_time`.
- R4: A software task with a nonzero execution time becomes done only on the clock edge after a cycle in which `sel_grant` is 1 while its unit's ready flag is 1. Its `finish` is then max(`asap`, `proc_time`) + `exec_time`.
- R5: `urgency` is 0 for a fabric task. For a software task it is the maximum over selected successors (`succ_mask`) of that successor's `succ_exec` when the successor's unit differs from the task's unit, or its `succ_urg` when the unit is the same. Code 11 counts as fabric. Successor i uses bits [2i+1:2i] of `succ_map` and bits [16i+15:16i] of the time vectors.
- R6: A task with `exec_time` 0 on any unit is done on the edge after it becomes ready, without a grant, and its `finish` equals `asap`.
- R7: Every finishing-time sum saturates at 16'hFFFF.
- R8: `chain_total_out` = max(`chain_total_in`, `finish`), and `chain_done_out` = `chain_done_in` AND done.
- R9: `rst` or `start` clears done and `finish` to 0 on the next edge. Otherwise done, once set, stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a new scheduling pass |
| exec_time | input | 16 | Task execution time |
| unit_map | input | 2 | Unit code of this task |
| pred_mask | input | NPRED | Selects the connected predecessors |
| pred_done | input | NPRED | Predecessor done flags |
| pred_finish | input | 16*NPRED | Predecessor finishing times |
| succ_mask | input | NSUCC | Selects the connected successors |
| succ_map | input | 2*NSUCC | Successor unit codes |
| succ_exec | input | 16*NSUCC | Successor execution times |
| succ_urg | input | 16*NSUCC | Successor urgency values |
| sel_grant | input | 1 | Processor selector picks this task |
| proc_time | input | 16 | Accumulated time of this task's processor |
| chain_total_in | input | 16 | Running graph total from the previous node |
| chain_done_in | input | 1 | Running all-done flag from the previous node |
| ready | output | 1 | All predecessors done |
| master_ready | output | 1 | Ready on master, not done |
| slave_ready | output | 1 | Ready on slave, not done |
| fabric_ready | output | 1 | Ready on fabric, not done |
| asap | output | 16 | Earliest start time |
| done | output | 1 | Task scheduled |
| finish | output | 16 | Finishing time |
| urgency | output | 16 | Urgency value |
| chain_total_out | output | 16 | Running graph total including this node |
| chain_done_out | output | 1 | Running all-done flag including this node |

## Verification
`ready`, the three qualified ready flags, `asap`, `urgency` and the chain outputs are combinational. The bench checks them one time step after it drives the inputs on a falling edge. `done` and `finish` pass through one register, so they are sampled on the falling edge after the rising edge that takes in the triggering condition: the readiness, the grant, or `start`/`rst`. For a software task the bench also samples one full cycle without a grant and checks that `done` is still 0 before it asserts the grant.

// File: rtl/task_node_pkg.sv
package task_node_pkg;

    parameter int TW = 16;

    typedef logic [TW-1:0] time_t;

    typedef enum logic [1:0] {
        UNIT_FABRIC = 2'b00,
        UNIT_MASTER = 2'b01,
        UNIT_SLAVE  = 2'b10,
        UNIT_SPARE  = 2'b11
    } unit_e;

    typedef struct packed {
        logic  done;
        time_t finish;
    } node_state_t;

    function automatic unit_e norm_unit(input logic [1:0] code);
        return (code == 2'b11) ? UNIT_FABRIC : unit_e'(code);
    endfunction

    function automatic time_t tmax(input time_t a, input time_t b);
        return (a > b) ? a : b;
    endfunction

    function automatic time_t sat_add(input time_t a, input time_t b);
        logic [TW:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[TW] ? {TW{1'b1}} : s[TW-1:0];
    endfunction

endpackage

// File: rtl/tnode_dep.sv
module tnode_dep
    import task_node_pkg::*;
#(
    parameter int NPRED = 3
) (
    input  logic [NPRED-1:0]    pred_mask,
    input  logic [NPRED-1:0]    pred_done,
    input  logic [TW*NPRED-1:0] pred_finish,
    output logic                ready,
    output time_t               asap
);
    time_t fin [NPRED];

    genvar g;
    generate
        for (g = 0; g < NPRED; g++) begin : g_unpack
            assign fin[g] = pred_finish[g*TW +: TW];
        end
    endgenerate

    always_comb begin
        ready = &(pred_done | ~pred_mask);
        asap  = '0;
        for (int i = 0; i < NPRED; i++) begin
            if (pred_mask[i]) asap = tmax(asap, fin[i]);
        end
    end
endmodule

// File: rtl/tnode_urgency.sv
module tnode_urgency
    import task_node_pkg::*;
#(
    parameter int NSUCC = 3
) (
    input  logic [1:0]          own_map,
    input  logic [NSUCC-1:0]    succ_mask,
    input  logic [2*NSUCC-1:0]  succ_map,
    input  logic [TW*NSUCC-1:0] succ_exec,
    input  logic [TW*NSUCC-1:0] succ_urg,
    output time_t               urgency
);
    time_t s_exec [NSUCC];
    time_t s_urg  [NSUCC];
    unit_e s_unit [NSUCC];
    unit_e own;

    genvar g;
    generate
        for (g = 0; g < NSUCC; g++) begin : g_unpack
            assign s_exec[g] = succ_exec[g*TW +: TW];
            assign s_urg[g]  = succ_urg[g*TW +: TW];
            assign s_unit[g] = norm_unit(succ_map[2*g +: 2]);
        end
    endgenerate

    assign own = norm_unit(own_map);

    always_comb begin
        urgency = '0;
        if (own != UNIT_FABRIC) begin
            for (int i = 0; i < NSUCC; i++) begin
                if (succ_mask[i]) begin
                    if (s_unit[i] != own) urgency = tmax(urgency, s_exec[i]);
                    else                  urgency = tmax(urgency, s_urg[i]);
                end
            end
        end
    end
endmodule

// File: rtl/tnode_state.sv
module tnode_state
    import task_node_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  unit_e       unit,
    input  logic        ready,
    input  time_t       asap,
    input  time_t       exec_time,
    input  time_t       proc_time,
    input  logic        sel_grant,
    output node_state_t st
);
    logic  is_sw;
    logic  launch;
    time_t start_t;

    always_comb begin
        is_sw   = (unit != UNIT_FABRIC);
        launch  = ready && !st.done &&
                  (!is_sw || (exec_time == '0) || sel_grant);
        start_t = (is_sw && exec_time != '0) ? tmax(asap, proc_time) : asap;
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            st <= '0;
        end else if (launch) begin
            st.done   <= 1'b1;
            st.finish <= sat_add(start_t, exec_time);
        end
    end
endmodule

// File: rtl/task_timing_node.sv
module task_timing_node
    import task_node_pkg::*;
#(
    parameter int NPRED = 3,
    parameter int NSUCC = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [TW-1:0]       exec_time,
    input  logic [1:0]          unit_map,
    input  logic [NPRED-1:0]    pred_mask,
    input  logic [NPRED-1:0]    pred_done,
    input  logic [TW*NPRED-1:0] pred_finish,
    input  logic [NSUCC-1:0]    succ_mask,
    input  logic [2*NSUCC-1:0]  succ_map,
    input  logic [TW*NSUCC-1:0] succ_exec,
    input  logic [TW*NSUCC-1:0] succ_urg,
    input  logic                sel_grant,
    input  logic [TW-1:0]       proc_time,
    input  logic [TW-1:0]       chain_total_in,
    input  logic                chain_done_in,
    output logic                ready,
    output logic                master_ready,
    output logic                slave_ready,
    output logic                fabric_ready,
    output logic [TW-1:0]       asap,
    output logic                done,
    output logic [TW-1:0]       finish,
    output logic [TW-1:0]       urgency,
    output logic [TW-1:0]       chain_total_out,
    output logic                chain_done_out
);
    unit_e       unit;
    node_state_t st;
    logic        pending;

    assign unit = norm_unit(unit_map);

    tnode_dep #(.NPRED(NPRED)) i_dep (
        .pred_mask   (pred_mask),
        .pred_done   (pred_done),
        .pred_finish (pred_finish),
        .ready       (ready),
        .asap        (asap)
    );

    tnode_urgency #(.NSUCC(NSUCC)) i_urg (
        .own_map   (unit_map),
        .succ_mask (succ_mask),
        .succ_map  (succ_map),
        .succ_exec (succ_exec),
        .succ_urg  (succ_urg),
        .urgency   (urgency)
    );

    tnode_state i_state (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .unit      (unit),
        .ready     (ready),
        .asap      (asap),
        .exec_time (exec_time),
        .proc_time (proc_time),
        .sel_grant (sel_grant),
        .st        (st)
    );

    assign done         = st.done;
    assign finish       = st.finish;
    assign pending      = ready && !st.done;
    assign master_ready = pending && (unit == UNIT_MASTER);
    assign slave_ready  = pending && (unit == UNIT_SLAVE);
    assign fabric_ready = pending && (unit == UNIT_FABRIC);

    assign chain_total_out = tmax(chain_total_in, st.finish);
    assign chain_done_out  = chain_done_in && st.done;
endmodule

// File: rtl/task_timing_node_chk.sv
module task_timing_node_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [15:0] exec_time,
    input logic [1:0]  unit_map,
    input logic        sel_grant,
    input logic        ready,
    input logic        master_ready,
    input logic        slave_ready,
    input logic        fabric_ready,
    input logic        done,
    input logic [15:0] urgency,
    input logic [15:0] chain_total_in,
    input logic [15:0] chain_total_out
);
    AST_DONE_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(ready)); // R1

    AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({master_ready, slave_ready, fabric_ready})); // R2

    AST_FABRIC_DONE: assert property (@(posedge clk) disable iff (rst)
        fabric_ready && !start |=> done); // R3

    AST_SW_WAITS_GRANT: assert property (@(posedge clk) disable iff (rst)
        (master_ready || slave_ready) && !sel_grant && exec_time != 16'd0 && !start
        |=> !done); // R4

    AST_URG_FABRIC_ZERO: assert property (@(posedge clk) disable iff (rst)
        (unit_map == 2'b00 || unit_map == 2'b11) |-> urgency == 16'd0); // R5

    AST_CHAIN_TOTAL: assert property (@(posedge clk) disable iff (rst)
        chain_total_out >= chain_total_in); // R8

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> done); // R9
endmodule

bind task_timing_node task_timing_node_chk i_chk (.*);

// File: tb/test_task_timing_node.sv
module test_task_timing_node;
    localparam int NP = 3;
    localparam int NS = 3;

    logic        clk = 1'b0;
    logic        rst, start, sel_grant, chain_done_in;
    logic [15:0] exec_time, proc_time, chain_total_in;
    logic [1:0]  unit_map;
    logic [NP-1:0]    pred_mask, pred_done;
    logic [16*NP-1:0] pred_finish;
    logic [NS-1:0]    succ_mask;
    logic [2*NS-1:0]  succ_map;
    logic [16*NS-1:0] succ_exec, succ_urg;
    logic        ready, master_ready, slave_ready, fabric_ready, done, chain_done_out;
    logic [15:0] asap, finish, urgency, chain_total_out;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    task_timing_node #(.NPRED(NP), .NSUCC(NS)) i_task_timing_node (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edge_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reset_node();
        rst = 1'b1;
        edge_step();
        rst = 1'b0;
    endtask

    task automatic t_reset();
        exec_time = 16'd7; unit_map = 2'b00; pred_mask = 3'b001; pred_done = 3'b000;
        chain_done_in = 1'b1; chain_total_in = 16'd0;
        reset_node();
        #1;
        check("R9 reset done", done, 0);
        check("R9 reset finish", finish, 0);
        check("R8 chain done after reset", chain_done_out, 0);
    endtask

    task automatic t_ready_asap();
        pred_mask = 3'b011; pred_done = 3'b001;
        pred_finish = {16'd99, 16'd25, 16'd10};
        reset_node();
        #1 check("R1 not ready", ready, 0);
        check("R2 no flag while waiting", fabric_ready, 0);
        pred_done = 3'b011;
        #1 check("R1 ready masked", ready, 1);
        check("R1 asap max", asap, 25);
        pred_mask = 3'b000;
        #1 check("R1 no preds ready", ready, 1);
        check("R1 no preds asap", asap, 0);
        pred_mask = 3'b011;
    endtask

    task automatic t_fabric();
        unit_map = 2'b00; exec_time = 16'd7;
        pred_mask = 3'b011; pred_done = 3'b011; pred_finish = {16'd99, 16'd25, 16'd10};
        reset_node();
        #1 check("R2 fabric_ready", fabric_ready, 1);
        check("R2 master flag low", master_ready, 0);
        edge_step();
        check("R3 fabric done", done, 1);
        check("R3 fabric finish", finish, 32);
        check("R2 flag clears when done", fabric_ready, 0);
        unit_map = 2'b11;
        reset_node();
        #1 check("R2 code 11 is fabric", fabric_ready, 1);
        edge_step();
        check("R3 code 11 done", done, 1);
    endtask

    task automatic t_software();
        unit_map = 2'b01; exec_time = 16'd5; proc_time = 16'd40; sel_grant = 1'b0;
        reset_node();
        #1 check("R2 master_ready", master_ready, 1);
        check("R2 fabric flag low", fabric_ready, 0);
        edge_step();
        check("R4 no grant not done", done, 0);
        sel_grant = 1'b1;
        edge_step();
        sel_grant = 1'b0;
        check("R4 granted done", done, 1);
        check("R4 finish from proc time", finish, 45);
        unit_map = 2'b10; proc_time = 16'd3;
        reset_node();
        #1 check("R2 slave_ready", slave_ready, 1);
        sel_grant = 1'b1;
        edge_step();
        sel_grant = 1'b0;
        check("R4 slave finish from asap", finish, 30);
    endtask

    task automatic t_urgency();
        unit_map = 2'b01; succ_mask = 3'b111;
        succ_map = {2'b10, 2'b01, 2'b00};
        succ_exec = {16'd4, 16'd50, 16'd13};
        succ_urg  = {16'd0, 16'd9, 16'd0};
        #1 check("R5 master other-unit max", urgency, 13);
        succ_urg = {16'd0, 16'd20, 16'd0};
        #1 check("R5 same-unit urgency passed back", urgency, 20);
        unit_map = 2'b00;
        #1 check("R5 fabric zero", urgency, 0);
        unit_map = 2'b10;
        #1 check("R5 slave other-unit", urgency, 50);
        succ_mask = 3'b101;
        #1 check("R5 masked successor ignored", urgency, 13);
        unit_map = 2'b01; succ_mask = 3'b001; succ_map = {2'b10, 2'b01, 2'b11};
        #1 check("R5 successor code 11 is fabric", urgency, 13);
    endtask

    task automatic t_zero();
        unit_map = 2'b01; exec_time = 16'd0; proc_time = 16'd40; sel_grant = 1'b0;
        reset_node();
        edge_step();
        check("R6 zero exec done without grant", done, 1);
        check("R6 zero exec finish is asap", finish, 25);
    endtask

    task automatic t_sat();
        unit_map = 2'b00; exec_time = 16'hFFF0;
        reset_node();
        edge_step();
        check("R7 saturated finish", finish, 16'hFFFF);
    endtask

    task automatic t_chain();
        unit_map = 2'b00; exec_time = 16'd7;
        reset_node();
        edge_step();
        chain_total_in = 16'd100; chain_done_in = 1'b1;
        #1 check("R8 chain total upstream larger", chain_total_out, 100);
        check("R8 chain done", chain_done_out, 1);
        chain_total_in = 16'd2; chain_done_in = 1'b0;
        #1 check("R8 chain total own finish", chain_total_out, 32);
        check("R8 chain done blocked", chain_done_out, 0);
    endtask

    task automatic t_start();
        start = 1'b1;
        edge_step();
        start = 1'b0;
        check("R9 start clears done", done, 0);
        check("R9 start clears finish", finish, 0);
        edge_step();
        check("R9 new pass completes", done, 1);
        edge_step();
        check("R9 done stays set", done, 1);
    endtask

    initial begin
        #2000000;
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; sel_grant = 1'b0; chain_done_in = 1'b0;
        exec_time = '0; proc_time = '0; chain_total_in = '0; unit_map = 2'b00;
        pred_mask = '0; pred_done = '0; pred_finish = '0;
        succ_mask = '0; succ_map = '0; succ_exec = '0; succ_urg = '0;
        @(negedge clk);
        t_reset();
        t_ready_asap();
        t_fabric();
        t_software();
        t_urgency();
        t_zero();
        t_sat();
        t_chain();
        t_start();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule